// File: doc/BRIEF.md
# Set-on-Compare Result Unit

This block produces the one-word result of a set-on-condition instruction. It compares a left operand against either a second register operand or a short immediate. The immediate is sign-extended to the word width first. The unit gives back a word that is zero everywhere except its lowest bit, which carries the truth of the tested relation.

The relation is picked by a 3-bit condition code, which the decoder takes from the low three bits of the opcode or function field. A separate control bit chooses between a two's-complement comparison and a plain magnitude comparison.

All relations come from one subtraction of the second operand from the first. Equality uses the zero flag. Signed ordering uses the sign of the difference combined with the overflow flag. Unsigned ordering uses the borrow out. The result is registered, so it appears one clock after the inputs are presented.

Top module: `scmp_unit`

## Requirements
- R1: Every bit of `set_word` above bit 0 is always zero.
- R2: Condition code 0 (equal) gives bit 0 = 1 exactly when the two compared values are identical.
- R3: Condition code 1 (not equal) gives bit 0 = 1 exactly when the compared values differ.
- R4: Condition code 2 (less than) gives bit 0 = 1 exactly when the left operand is below the right one.
- R5: Condition code 3 (greater than) gives bit 0 = 1 exactly when the left operand is above the right one.
- R6: Condition code 4 (less or equal) gives bit 0 = 1 when the left operand is below or equal to the right one.
- R7: Condition code 5 (greater or equal) gives bit 0 = 1 when the left operand is above or equal to the right one.
- R8: With `is_unsigned` = 0 the ordering treats both values as two's-complement numbers. With `is_unsigned` = 1 they are treated as unsigned magnitudes.
- R9: Condition codes 6 and 7 always give an all-zero result.
- R10: With `use_imm` = 1 the right operand is `imm` sign-extended from bit IMM_W-1 to WIDTH bits, and `opnd_b` has no effect on the result. With `use_imm` = 0 the right operand is `opnd_b`.
- R11: The result is registered: inputs applied before a rising edge show up on `set_word` after that edge. While `rst_n` is low, `set_word` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opnd_a | input | WIDTH | Left operand |
| opnd_b | input | WIDTH | Right register operand |
| imm | input | IMM_W | Immediate, sign-extended before use |
| use_imm | input | 1 | 1 selects the immediate as the right operand |
| cond_code | input | 3 | Relation to test (0 eq, 1 ne, 2 lt, 3 gt, 4 le, 5 ge) |
| is_unsigned | input | 1 | 0 signed comparison, 1 unsigned comparison |
| set_word | output | WIDTH | Registered result, bit 0 holds the outcome |

## Verification
A narrow 4-bit instance with a 3-bit immediate is swept exhaustively. The sweep covers every operand pair, every condition code and both signedness settings, in both register and immediate form. Pairs whose signed and unsigned orderings disagree separate the two modes. Equal pairs separate strict relations from their inclusive forms. The register operand is given junk values while the immediate is in use, which shows that it is ignored. A full-width instance is then driven with boundary pairs around the most negative and most positive values, all-ones and zero. It also gets immediates with the top bit set, which exposes sign-extension and overflow errors.

// File: rtl/scmp_pkg.sv
package scmp_pkg;

  typedef enum logic [2:0] {
    CC_EQ  = 3'd0,
    CC_NE  = 3'd1,
    CC_LT  = 3'd2,
    CC_GT  = 3'd3,
    CC_LE  = 3'd4,
    CC_GE  = 3'd5,
    CC_RSV6 = 3'd6,
    CC_RSV7 = 3'd7
  } cond_e;

  typedef struct packed {
    logic zero;
    logic borrow;
    logic ovf;
    logic sign;
  } sub_flags_t;

  function automatic logic code_is_defined(input logic [2:0] code);
    return code <= 3'd5;
  endfunction

endpackage

// File: rtl/scmp_operand_sel.sv
module scmp_operand_sel #(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16
) (
  input  logic [WIDTH-1:0] reg_b,
  input  logic [IMM_W-1:0] imm,
  input  logic             use_imm,
  output logic [WIDTH-1:0] rhs
);

  logic [WIDTH-1:0] imm_ext;

  generate
    if (IMM_W >= WIDTH) begin : g_trunc
      assign imm_ext = imm[WIDTH-1:0];
    end else begin : g_sext
      localparam int PAD = WIDTH - IMM_W;
      assign imm_ext = {{PAD{imm[IMM_W-1]}}, imm};
    end
  endgenerate

  assign rhs = use_imm ? imm_ext : reg_b;

  always_comb begin
    if (use_imm)
      AST_IMM_SIGN_KEPT: assert (rhs[WIDTH-1] == imm[IMM_W-1] || IMM_W > WIDTH); // R10
  end

endmodule

// File: rtl/scmp_subtractor.sv
module scmp_subtractor
  import scmp_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] lhs,
  input  logic [WIDTH-1:0] rhs,
  output sub_flags_t       flags
);

  localparam int MSB = WIDTH - 1;

  function automatic logic [WIDTH:0] sub_ext(input logic [WIDTH-1:0] x,
                                              input logic [WIDTH-1:0] y);
    return {1'b0, x} + {1'b0, ~y} + {{WIDTH{1'b0}}, 1'b1};
  endfunction

  logic [WIDTH:0]   raw;
  logic [WIDTH-1:0] diff;
  logic             carry_out;

  assign raw       = sub_ext(lhs, rhs);
  assign diff      = raw[WIDTH-1:0];
  assign carry_out = raw[WIDTH];

  assign flags.zero   = (diff == '0);
  assign flags.borrow = ~carry_out;
  assign flags.sign   = diff[MSB];
  assign flags.ovf    = (lhs[MSB] ^ rhs[MSB]) & (diff[MSB] ^ lhs[MSB]);

  always_comb begin
    AST_ZERO_MEANS_EQUAL: assert (flags.zero == (lhs == rhs));                                // R2
    AST_BORROW_MEANS_BELOW: assert (flags.borrow == (lhs < rhs));                              // R8
    AST_SIGNED_ORDER: assert ((flags.sign ^ flags.ovf) == ($signed(lhs) < $signed(rhs)));     // R8
  end

endmodule

// File: rtl/scmp_cond_eval.sv
module scmp_cond_eval
  import scmp_pkg::*;
(
  input  sub_flags_t flags,
  input  logic [2:0] cond_code,
  input  logic       is_unsigned,
  output logic       outcome
);

  logic is_eq, is_lt, is_gt;

  assign is_eq = flags.zero;
  assign is_lt = is_unsigned ? flags.borrow : (flags.sign ^ flags.ovf);
  assign is_gt = ~is_lt & ~is_eq;

  always_comb begin
    unique case (cond_e'(cond_code))
      CC_EQ:   outcome = is_eq;
      CC_NE:   outcome = ~is_eq;
      CC_LT:   outcome = is_lt;
      CC_GT:   outcome = is_gt;
      CC_LE:   outcome = is_lt | is_eq;
      CC_GE:   outcome = ~is_lt;
      default: outcome = 1'b0;
    endcase
  end

  always_comb begin
    AST_EQ_NOT_BELOW: assert (!(is_eq && is_lt));                       // R4
    AST_RSV_CODE_LOW: assert (code_is_defined(cond_code) || !outcome);  // R9
  end

endmodule

// File: rtl/scmp_unit.sv
module scmp_unit
  import scmp_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int IMM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [IMM_W-1:0] imm,
  input  logic             use_imm,
  input  logic [2:0]       cond_code,
  input  logic             is_unsigned,
  output logic [WIDTH-1:0] set_word
);

  logic [WIDTH-1:0] rhs;
  sub_flags_t       flags;
  logic             outcome;

  scmp_operand_sel #(.WIDTH(WIDTH), .IMM_W(IMM_W)) u_sel (
    .reg_b   (opnd_b),
    .imm     (imm),
    .use_imm (use_imm),
    .rhs     (rhs)
  );

  scmp_subtractor #(.WIDTH(WIDTH)) u_sub (
    .lhs   (opnd_a),
    .rhs   (rhs),
    .flags (flags)
  );

  scmp_cond_eval u_eval (
    .flags       (flags),
    .cond_code   (cond_code),
    .is_unsigned (is_unsigned),
    .outcome     (outcome)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) set_word <= '0;
    else        set_word <= {{(WIDTH-1){1'b0}}, outcome};
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) !rst_n |=> set_word == '0); // R11
  AST_RSV_GIVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_code > 3'd5) |=> set_word == '0); // R9
  AST_EQ_NE_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_code == 3'd1 && opnd_a == rhs) |=> !set_word[0]); // R3

endmodule

// File: tb/scmp_unit_tb.sv
module scmp_unit_tb;

  localparam int NW = 4;
  localparam int NI = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] a32, b32, y32;
  logic [15:0] i32;
  logic        ui32, uu32;
  logic [2:0]  c32;

  logic [NW-1:0] an, bn, yn;
  logic [NI-1:0] inn;
  logic          uin, uun;
  logic [2:0]    cn;

  scmp_unit #(.WIDTH(32), .IMM_W(16)) u_dut (
    .clk(clk), .rst_n(rst_n), .opnd_a(a32), .opnd_b(b32), .imm(i32),
    .use_imm(ui32), .cond_code(c32), .is_unsigned(uu32), .set_word(y32));

  scmp_unit #(.WIDTH(NW), .IMM_W(NI)) u_dut_nar (
    .clk(clk), .rst_n(rst_n), .opnd_a(an), .opnd_b(bn), .imm(inn),
    .use_imm(uin), .cond_code(cn), .is_unsigned(uun), .set_word(yn));

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  function automatic longint as_signed(longint v, int w);
    return (v >= (longint'(1) <<< (w-1))) ? v - (longint'(1) <<< w) : v;
  endfunction

  function automatic longint sext(longint v, int iw, int w);
    longint s = as_signed(v, iw);
    return s < 0 ? s + (longint'(1) <<< w) : s;
  endfunction

  function automatic bit ref_bit(longint a, longint b, int code, bit uns, int w);
    longint x = uns ? a : as_signed(a, w);
    longint y = uns ? b : as_signed(b, w);
    case (code)
      0: return x == y;
      1: return x != y;
      2: return x < y;
      3: return x > y;
      4: return x <= y;
      5: return x >= y;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string req_of(int code);
    case (code)
      0: return "R2";
      1: return "R3";
      2: return "R4/R8";
      3: return "R5/R8";
      4: return "R6/R8";
      5: return "R7/R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(string req, longint act, longint exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_nar(int a, int b, int im, bit use_i, int code, bit uns);
    longint rhs;
    @(negedge clk);
    an = NW'(a); bn = NW'(b); inn = NI'(im); uin = use_i; cn = 3'(code); uun = uns;
    rhs = use_i ? sext(im, NI, NW) : longint'(b);
    @(posedge clk); #1;
    // R1 R11: upper bits zero, result after one edge
    check(use_i ? {req_of(code), " R10 R1 R11"} : {req_of(code), " R1 R11"},
          longint'(yn), longint'(ref_bit(a, rhs, code, uns, NW)));
  endtask

  task automatic run_wide(longint a, longint b, int im, bit use_i, int code, bit uns);
    longint rhs;
    @(negedge clk);
    a32 = 32'(a); b32 = 32'(b); i32 = 16'(im); ui32 = use_i; c32 = 3'(code); uu32 = uns;
    rhs = use_i ? sext(im, 16, 32) : b;
    @(posedge clk); #1;
    check(use_i ? {req_of(code), " R10 wide"} : {req_of(code), " wide"},
          longint'(y32), longint'(ref_bit(a, rhs, code, uns, 32)));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    longint wa [8] = '{0, 32'h7fffffff, 32'h80000000, 32'hffffffff, 1, 5, 32'h80000001, 32'hffff8000};
    longint wb [8] = '{0, 32'h80000000, 32'h7fffffff, 1, 32'hffffffff, 5, 32'h00000001, 32'hffff8000};
    a32 = '1; b32 = '1; i32 = '1; ui32 = 0; c32 = 0; uu32 = 0;
    an = '1; bn = '1; inn = '1; uin = 0; cn = 0; uun = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset wide", longint'(y32), 0);
    check("R11 reset narrow", longint'(yn), 0);
    @(negedge clk); rst_n = 1'b1;

    // exhaustive register form
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int code = 0; code < 8; code++)
          for (int u = 0; u < 2; u++)
            run_nar(a, b, b ^ 5, 1'b0, code, u[0]);

    // exhaustive immediate form, register operand given junk (R10)
    for (int a = 0; a < 16; a++)
      for (int im = 0; im < 8; im++)
        for (int code = 0; code < 8; code++)
          for (int u = 0; u < 2; u++)
            run_nar(a, (a * 7 + im) & 15, im, 1'b1, code, u[0]);

    // wide boundary pairs
    for (int k = 0; k < 8; k++)
      for (int code = 0; code < 8; code++)
        for (int u = 0; u < 2; u++)
          run_wide(wa[k], wb[k], 0, 1'b0, code, u[0]);

    // wide immediates with top bit set
    for (int code = 0; code < 8; code++)
      for (int u = 0; u < 2; u++) begin
        run_wide(32'hffffffff, 32'h0, 16'hffff, 1'b1, code, u[0]);
        run_wide(32'hffff8000, 32'h0, 16'h8000, 1'b1, code, u[0]);
        run_wide(32'h00007fff, 32'hffffffff, 16'h8000, 1'b1, code, u[0]);
        run_wide(32'h00000003, 32'h80000000, 16'h0004, 1'b1, code, u[0]);
      end

    // reset mid-run clears result (R11)
    run_wide(1, 1, 0, 1'b0, 0, 1'b0);
    @(negedge clk); rst_n = 1'b0; #1;
    check("R11 async clear", longint'(y32), 0);
    @(negedge clk); rst_n = 1'b1;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule